// File: doc/BRIEF.md
# Dual Programmable Clock Divider

This block turns one fast oscillator clock into two slower clocks. The core
output divides the oscillator by a power of two. The system output divides it
by any whole number from 1 to 15. Both ratios live in a divider register that
is reached through a small synchronous write/read port. Software may rewrite
either ratio at any moment. The new ratio takes effect at the end of the period
that is running, with no wait for the oscillator to settle.

A second register holds a 6-bit multiplier code. This code goes straight to the
frequency synthesiser that sits outside the block. The same register also
controls an external clock pin. The pin is off after reset. Once enabled, it
carries either the divided system clock or a buffered copy of the reference
clock. The synthesiser runs the oscillator at a multiple of that reference.

Top module: `clkdiv_dual`

## Requirements
- R1: The system divide code is bits [3:0] of the divider register (address 0). A code of 1 to 15 divides the oscillator by that number. A code of 0 divides by 1 and never stops the clock, and the register reads the 0 back. A ratio of 1 outputs the oscillator clock itself.
- R2: For a system ratio N of 2 or more, each period starts with floor(N/2) oscillator cycles high, followed by ceil(N/2) cycles low.
- R3: The core divide code is bits [5:4] of the divider register. Code 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. The waveform shape is the one given in R2.
- R4: A new ratio for either output is taken up only when the current output period ends. The period in progress therefore finishes with its old high and low lengths, and the next period uses the new lengths.
- R5: After reset the divider register reads 0x05, which selects system ratio 5 and core ratio 1. The control register (address 1) reads 0x06.
- R6: Raising the read strobe loads the addressed register onto the read data bus at the next clock edge. The bus holds its value while the strobe is low. Bits [7:6] of the divider register always read 0.
- R7: The multiplier code is bits [5:0] of the control register. Its reset value is 6, and code 0 stands for 64. A write carrying code 1, 2, 3 or 4 leaves the stored code unchanged. The stored code drives the multiplier output.
- R8: Control bit 6 enables the external pin. It is 0 after reset. While the pin is disabled, the output-enable signal is low and the pin data is 0.
- R9: Control bit 7 selects the pin source while the pin is enabled. A value of 0 selects the system clock and a value of 1 selects the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock; all registers run on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock used by the synthesiser |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 divider, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pll_mult | output | 6 | Stored multiplier code for the synthesiser |
| core_clk | output | 1 | Power-of-two divided clock |
| sys_clk | output | 1 | Integer divided clock |
| ext_clk_o | output | 1 | External pin data |
| ext_clk_oe | output | 1 | External pin output enable |

## Verification
The bench builds the block with its default parameters: reset codes of system ratio 5, core ratio 1 and multiplier 6, with a reference clock period of six oscillator cycles. With these values every system code from 0 to 15 and every core code can be measured. The bench counts oscillator half-cycles between output edges, so the divide-by-1 pass-through and the uneven split for odd ratios can be told apart. It also changes the ratio in the middle of a period, going up, going down and into pass-through, to show that the old period finishes before the new ratio starts.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DATA_W  = 8;
    localparam int SYS_W   = 4;
    localparam int CORE_W  = 2;
    localparam int MULT_W  = 6;
    localparam int RATIO_W = SYS_W;
    localparam int NUM_DIV = 2;
    localparam int MULT_MIN = 5;

    typedef struct packed {
        logic [DATA_W-SYS_W-CORE_W-1:0] rsvd;
        logic [CORE_W-1:0]              core;
        logic [SYS_W-1:0]               sys;
    } div_reg_t;

    typedef struct packed {
        logic              src;
        logic              en;
        logic [MULT_W-1:0] mult;
    } ctl_reg_t;

    typedef enum logic {
        ADDR_DIV = 1'b0,
        ADDR_CTL = 1'b1
    } reg_addr_e;

    typedef enum logic {
        PIN_SYS = 1'b0,
        PIN_REF = 1'b1
    } pin_src_e;

    // Ratio used by the integer divider; zero falls back to pass-through.
    function automatic logic [RATIO_W-1:0] sys_ratio(input logic [SYS_W-1:0] code);
        return (code == '0) ? RATIO_W'(1) : RATIO_W'(code);
    endfunction

    function automatic logic [RATIO_W-1:0] core_ratio(input logic [CORE_W-1:0] code);
        return RATIO_W'(1) << code;
    endfunction

    // Code 0 encodes 64; codes below the minimum are rejected.
    function automatic logic mult_ok(input logic [MULT_W-1:0] code);
        return (code == '0) || (int'(code) >= MULT_MIN);
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter div_reg_t RST_DIV = '{rsvd: '0, core: '0, sys: SYS_W'(5)},
    parameter ctl_reg_t RST_CTL = '{src: 1'b0, en: 1'b0, mult: MULT_W'(6)}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output div_reg_t          div_q,
    output ctl_reg_t          ctl_q
);

    ctl_reg_t wr_ctl;
    assign wr_ctl = ctl_reg_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= RST_DIV;
            ctl_q <= RST_CTL;
            rdata <= '0;
        end else begin
            if (we) begin
                unique case (reg_addr_e'(addr))
                    ADDR_DIV: begin
                        div_q.sys  <= wdata[SYS_W-1:0];
                        div_q.core <= wdata[SYS_W+CORE_W-1:SYS_W];
                    end
                    ADDR_CTL: begin
                        ctl_q.en  <= wr_ctl.en;
                        ctl_q.src <= wr_ctl.src;
                        if (mult_ok(wr_ctl.mult)) begin
                            ctl_q.mult <= wr_ctl.mult;
                        end
                    end
                    default: ;
                endcase
            end
            if (re) begin
                rdata <= (reg_addr_e'(addr) == ADDR_DIV) ? DATA_W'(div_q) : DATA_W'(ctl_q);
            end
        end
    end

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
    import clkdiv_pkg::*;
#(
    parameter int RST_RATIO = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic               clk_out
);

    localparam logic [RATIO_W-1:0] RST_R = RATIO_W'(RST_RATIO);

    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] ratio_cur;
    logic               phase_q;
    logic               bypass_q;
    logic               at_end;
    logic [RATIO_W-1:0] cnt_nx;

    assign at_end = (cnt == ratio_cur - RATIO_W'(1));
    assign cnt_nx = cnt + RATIO_W'(1);

    // New ratio is picked up only at the end of the running period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            ratio_cur <= RST_R;
            phase_q   <= (RST_R >= RATIO_W'(2));
            bypass_q  <= (RST_R == RATIO_W'(1));
        end else if (at_end) begin
            cnt       <= '0;
            ratio_cur <= ratio_req;
            phase_q   <= (ratio_req >= RATIO_W'(2));
            bypass_q  <= (ratio_req == RATIO_W'(1));
        end else begin
            cnt     <= cnt_nx;
            phase_q <= (cnt_nx < (ratio_cur >> 1));
        end
    end

    assign clk_out = bypass_q ? clk : phase_q;

endmodule

// File: rtl/clkdiv_pinmux.sv
module clkdiv_pinmux
    import clkdiv_pkg::*;
(
    input  logic en,
    input  logic src,
    input  logic sys_clk,
    input  logic ref_clk,
    output logic pin_o,
    output logic pin_oe
);

    logic picked;

    always_comb begin
        unique case (pin_src_e'(src))
            PIN_REF: picked = ref_clk;
            default: picked = sys_clk;
        endcase
    end

    assign pin_oe = en;
    assign pin_o  = en & picked;

endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
    import clkdiv_pkg::*;
#(
    parameter int RST_SYS_CODE  = 5,
    parameter int RST_CORE_CODE = 0,
    parameter int RST_MULT      = 6
) (
    input  logic              vco_clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [MULT_W-1:0] pll_mult,
    output logic              core_clk,
    output logic              sys_clk,
    output logic              ext_clk_o,
    output logic              ext_clk_oe
);

    localparam div_reg_t RST_DIV = '{rsvd: '0, core: CORE_W'(RST_CORE_CODE), sys: SYS_W'(RST_SYS_CODE)};
    localparam ctl_reg_t RST_CTL = '{src: 1'b0, en: 1'b0, mult: MULT_W'(RST_MULT)};
    localparam int RST_RATIO [NUM_DIV] = '{int'(core_ratio(RST_DIV.core)), int'(sys_ratio(RST_DIV.sys))};

    div_reg_t           div_q;
    ctl_reg_t           ctl_q;
    logic [RATIO_W-1:0] ratio_req [NUM_DIV];
    logic [NUM_DIV-1:0] div_out;

    clkdiv_regs #(
        .RST_DIV (RST_DIV),
        .RST_CTL (RST_CTL)
    ) u_regs (
        .clk   (vco_clk),
        .rst   (rst),
        .we    (reg_we),
        .re    (reg_re),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .div_q (div_q),
        .ctl_q (ctl_q)
    );

    assign ratio_req[0] = core_ratio(div_q.core);
    assign ratio_req[1] = sys_ratio(div_q.sys);

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        clkdiv_stage #(
            .RST_RATIO (RST_RATIO[g])
        ) u_stage (
            .clk       (vco_clk),
            .rst       (rst),
            .ratio_req (ratio_req[g]),
            .clk_out   (div_out[g])
        );
    end

    assign core_clk = div_out[0];
    assign sys_clk  = div_out[1];
    assign pll_mult = ctl_q.mult;

    clkdiv_pinmux u_pin (
        .en      (ctl_q.en),
        .src     (ctl_q.src),
        .sys_clk (sys_clk),
        .ref_clk (ref_clk),
        .pin_o   (ext_clk_o),
        .pin_oe  (ext_clk_oe)
    );

endmodule

// File: rtl/clkdiv_dual_chk.sv
module clkdiv_dual_chk (
    input logic       vco_clk,
    input logic       rst,
    input logic       reg_we,
    input logic       reg_re,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [5:0] pll_mult,
    input logic       ext_clk_o,
    input logic       ext_clk_oe
);

    AST_PIN_OFF_AFTER_RESET: assert property (@(posedge vco_clk) rst |=> !ext_clk_oe); // R8

    AST_PIN_QUIET: assert property (@(posedge vco_clk) disable iff (rst)
        !ext_clk_oe |-> !ext_clk_o); // R8

    AST_PIN_ENABLE_WRITE: assert property (@(posedge vco_clk) disable iff (rst)
        (reg_we && reg_addr) |=> (ext_clk_oe == $past(reg_wdata[6]))); // R8

    AST_RDATA_HOLD: assert property (@(posedge vco_clk) disable iff (rst)
        !reg_re |=> $stable(reg_rdata)); // R6

    AST_DIV_RSVD_ZERO: assert property (@(posedge vco_clk) disable iff (rst)
        (reg_re && !reg_addr) |=> (reg_rdata[7:6] == 2'b00)); // R6

    AST_MULT_LEGAL: assert property (@(posedge vco_clk) disable iff (rst)
        !(pll_mult inside {6'd1, 6'd2, 6'd3, 6'd4})); // R7

    AST_MULT_REJECT: assert property (@(posedge vco_clk) disable iff (rst)
        (reg_we && reg_addr && (reg_wdata[5:0] inside {6'd1, 6'd2, 6'd3, 6'd4})) |=> $stable(pll_mult)); // R7

endmodule

bind clkdiv_dual clkdiv_dual_chk u_chk (.*);

// File: tb/clkdiv_dual_tb.sv
module clkdiv_dual_tb;

    localparam int VCO_PERIOD = 10;
    localparam int REF_HALF   = 3 * VCO_PERIOD;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] pll_mult;
    logic       core_clk, sys_clk, ext_clk_o, ext_clk_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #(VCO_PERIOD/2) vco_clk = ~vco_clk;
    always #(REF_HALF) ref_clk = ~ref_clk;

    clkdiv_dual u_dut (
        .vco_clk(vco_clk), .rst(rst), .ref_clk(ref_clk),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_mult(pll_mult),
        .core_clk(core_clk), .sys_clk(sys_clk),
        .ext_clk_o(ext_clk_o), .ext_clk_oe(ext_clk_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_hi(input int n);
        return (n == 1) ? 1 : 2 * (n / 2);
    endfunction

    function automatic int exp_lo(input int n);
        return (n == 1) ? 1 : 2 * (n - n / 2);
    endfunction

    function automatic logic pick(input int which);
        return (which == 0) ? core_clk : sys_clk;
    endfunction

    task automatic half_step();
        @(vco_clk);
        #1;
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge vco_clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge vco_clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] d);
        @(negedge vco_clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge vco_clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    // Half-cycle lengths of one high run and the low run after it.
    task automatic measure(input int which, output int hi, output int lo);
        logic prev, cur;
        int guard = 0;
        half_step(); prev = pick(which);
        half_step(); cur = pick(which);
        while (!(!prev && cur) && guard < 200) begin
            prev = cur; half_step(); cur = pick(which); guard++;
        end
        hi = 1;
        half_step(); cur = pick(which);
        while (cur && guard < 200) begin hi++; half_step(); cur = pick(which); guard++; end
        lo = 1;
        half_step(); cur = pick(which);
        while (!cur && guard < 200) begin lo++; half_step(); cur = pick(which); guard++; end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int hi, lo;
        check("R8", "oe after reset", int'(ext_clk_oe), 0);
        check("R8", "pin data after reset", int'(ext_clk_o), 0);
        check("R7", "mult after reset", int'(pll_mult), 6);
        reg_read(1'b0, d); check("R5", "divider reg reset", int'(d), 8'h05);
        reg_read(1'b1, d); check("R5", "control reg reset", int'(d), 8'h06);
        measure(1, hi, lo);
        check("R2", "reset sys high", hi, exp_hi(5));
        check("R2", "reset sys low", lo, exp_lo(5));
        measure(0, hi, lo);
        check("R3", "reset core high", hi, 1);
        check("R3", "reset core low", lo, 1);
    endtask

    task automatic t_sys_all();
        logic [7:0] d;
        int hi, lo, n;
        for (int code = 0; code < 16; code++) begin
            reg_write(1'b0, 8'(8'h10 | code));
            repeat (40) @(posedge vco_clk);
            measure(1, hi, lo);
            n = (code == 0) ? 1 : code;
            check((n % 2) ? "R2" : "R1", $sformatf("sys code %0d high", code), hi, exp_hi(n));
            check((n % 2) ? "R2" : "R1", $sformatf("sys code %0d low", code), lo, exp_lo(n));
            if (code == 0) begin
                reg_read(1'b0, d);
                check("R1", "code 0 reads back", int'(d[3:0]), 0);
            end
        end
    endtask

    task automatic t_core_all();
        int hi, lo;
        for (int c = 0; c < 4; c++) begin
            reg_write(1'b0, 8'((c << 4) | 5));
            repeat (40) @(posedge vco_clk);
            measure(0, hi, lo);
            check("R3", $sformatf("core code %0d high", c), hi, exp_hi(1 << c));
            check("R3", $sformatf("core code %0d low", c), lo, exp_lo(1 << c));
        end
    endtask

    // Change the sys ratio during a high phase; the old period must finish first.
    task automatic t_midchange(input int old_n, input int new_n);
        logic prev, cur;
        int runs [4];
        int idx = 0, len = 1, guard = 0, k = 0;
        reg_write(1'b0, 8'(old_n));
        repeat (40) @(posedge vco_clk);
        half_step(); prev = sys_clk;
        half_step(); cur = sys_clk;
        while (!(!prev && cur) && guard < 200) begin
            prev = cur; half_step(); cur = sys_clk; guard++;
        end
        while (idx < 4 && guard < 400) begin
            half_step(); k++; guard++;
            if (k == 1) begin reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'(new_n); end
            if (k == 3) reg_we = 1'b0;
            if (sys_clk == cur) len++;
            else begin runs[idx] = len; idx++; len = 1; cur = sys_clk; end
        end
        check("R4", $sformatf("%0d->%0d old high", old_n, new_n), runs[0], exp_hi(old_n));
        check("R4", $sformatf("%0d->%0d old low", old_n, new_n), runs[1], exp_lo(old_n));
        check("R4", $sformatf("%0d->%0d new high", old_n, new_n), runs[2], exp_hi(new_n));
        check("R4", $sformatf("%0d->%0d new low", old_n, new_n), runs[3], exp_lo(new_n));
    endtask

    task automatic t_pin();
        int bad;
        reg_write(1'b0, 8'h03);
        reg_write(1'b1, 8'h46);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            half_step();
            if (ext_clk_o != sys_clk || !ext_clk_oe) bad++;
        end
        check("R9", "pin follows sys clock", bad, 0);
        reg_write(1'b1, 8'hC6);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            half_step();
            if (ext_clk_o != ref_clk || !ext_clk_oe) bad++;
        end
        check("R9", "pin follows reference", bad, 0);
        reg_write(1'b1, 8'h86);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            half_step();
            if (ext_clk_o || ext_clk_oe) bad++;
        end
        check("R8", "disabled pin quiet", bad, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d, held;
        reg_write(1'b1, 8'h03);
        reg_read(1'b1, d);
        check("R7", "mult code 3 rejected", int'(d[5:0]), 6);
        check("R7", "mult port after reject", int'(pll_mult), 6);
        reg_write(1'b1, 8'h00);
        check("R7", "mult code 0 (64) taken", int'(pll_mult), 0);
        reg_write(1'b1, 8'h28);
        check("R7", "mult code 40 taken", int'(pll_mult), 40);
        reg_write(1'b1, 8'h05);
        check("R7", "mult code 5 taken", int'(pll_mult), 5);
        reg_write(1'b0, 8'hFF);
        reg_read(1'b0, d);
        check("R6", "divider reserved bits", int'(d), 8'h3F);
        held = d;
        reg_write(1'b0, 8'h12);
        repeat (3) @(posedge vco_clk);
        #1;
        check("R6", "rdata holds without strobe", int'(reg_rdata), int'(held));
        reg_read(1'b0, d);
        check("R6", "rdata after new read", int'(d), 8'h12);
    endtask

    initial begin
        #(VCO_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge vco_clk);
        @(negedge vco_clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_sys_all();
        t_core_all();
        t_midchange(15, 2);
        t_midchange(4, 9);
        t_midchange(3, 1);
        t_pin();
        t_regs();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule